// File: doc/BRIEF.md
# Burst Address Sequencer for a Pipelined Bus Master

This block sits inside a bus master on a pipelined on-chip bus. The data source gives it a start pulse, a start address, a 3-bit burst code and a 3-bit transfer-size code. From these it produces the address-phase stream for every beat: a 32-bit address, a 2-bit transfer type, a flag that marks the final beat, and a one-cycle completion pulse. The address and type for a beat are shown one cycle before that beat's data phase. Every output stays frozen while the bus holds `ready` low.

Incrementing bursts step the address by the transfer size in bytes. Wrapping bursts keep the address inside an aligned window of size times beat count, so a start address that is not aligned to the window wraps back to the window's base. A stall request from the data source turns the next address phase into a BUSY beat. The address of a BUSY beat already shows the next beat's value, and no beat is consumed until the stall is released.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `trans` is IDLE (00), `addr` is 0, and `last` and `done` are 0.
- R2: When `trans` is IDLE and `ready` is high, a high `start` is accepted. The next cycle shows `addr` = `start_addr` with `trans` = NONSEQ (10). `start`, `start_addr`, `burst` and `size` have no effect while a burst is in progress, and `start` is not accepted while `ready` is low.
- R3: The burst code sets the beat count: 000 single (1 beat), 001 undefined length, 010 wrap 4, 011 increment 4, 100 wrap 8, 101 increment 8, 110 wrap 16, 111 increment 16. After the final beat is accepted, `trans` returns to IDLE.
- R4: In an incrementing burst, each beat's address is the previous beat's address plus 2^`size` bytes, modulo 2^32.
- R5: In a wrapping burst with N beats, address bits at and above position `size`+log2(N) stay equal to those of the start address. The bits below that position equal (start + i·2^`size`) modulo 2^(`size`+log2(N)) for beat i.
- R6: Every beat after the first is shown with `trans` = SEQ (11), and no burst shows a second NONSEQ.
- R7: While `ready` is low, `addr`, `trans` and `last` hold their values.
- R8: When a non-final beat is accepted while `stall` is high, the next phase is BUSY (01) with the next beat's address. BUSY repeats while `stall` stays high. When `stall` goes low, the same address is shown as SEQ. A stall on the final beat has no effect.
- R9: `last` is high exactly on the final beat of a fixed-length burst (including single). It is never high on BUSY beats, and never high in an undefined-length burst.
- R10: `done` goes high for exactly one cycle, in the cycle after the final beat is accepted, and `trans` is IDLE in that cycle.
- R11: An undefined-length burst continues while `start` is held high. The beat accepted while `start` is low is its final beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a burst; held high to extend an undefined-length burst |
| start_addr | input | 32 | Address of the first beat |
| burst | input | 3 | Burst code (see R3) |
| size | input | 3 | Transfer size code, 2^size bytes |
| ready | input | 1 | Bus accepts the current address phase |
| stall | input | 1 | Data source asks for BUSY beats |
| addr | output | 32 | Address of the current address phase |
| trans | output | 2 | Transfer type: IDLE 00, BUSY 01, NONSEQ 10, SEQ 11 |
| last | output | 1 | Current beat is the final one |
| done | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
The bench sweeps every burst code against every size code, using three start addresses. One start address sits near the top of the address space, so incrementing bursts roll over and wrapping bursts start at different offsets inside their window. Each combination runs under three handshake patterns: ready always high, which isolates the address arithmetic; periodic ready gaps, which separate holding (R7) from advancing; and ready gaps combined with periodic stalls, which show whether a BUSY beat consumes a beat or moves the address. Throughout each burst, `start_addr`, `burst` and `start` are driven with other values, so any leak of live inputs into a running burst shows up. In undefined-length bursts, dropping `start` shows whether the burst ends on the right beat.

// File: rtl/bag_pkg.sv
package bag_pkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_BUSY = 2'b01,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_t;

  localparam logic [2:0] BC_SINGLE = 3'b000;
  localparam logic [2:0] BC_INCR   = 3'b001;

endpackage

// File: rtl/bag_decode.sv
module bag_decode
  import bag_pkg::*;
#(
  parameter int LGB_W = 3
) (
  input  logic [2:0]       code_i,
  output logic [LGB_W-1:0] lg_o,
  output logic             wrap_o,
  output logic             undef_o
);

  // code[2:1] gives log2(beats)-1 for the fixed bursts; 00 marks single or undefined
  always_comb begin
    if (code_i[2:1] == 2'b00) lg_o = '0;
    else                      lg_o = LGB_W'(code_i[2:1]) + LGB_W'(1);
    wrap_o  = (code_i[0] == 1'b0) && (code_i != BC_SINGLE);
    undef_o = (code_i == BC_INCR);
  end

endmodule

// File: rtl/bag_step.sv
module bag_step #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int LGB_W  = 3,
  parameter int LG_W   = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [LGB_W-1:0]  lg_i,
  input  logic              wrap_i,
  output logic [ADDR_W-1:0] next_o
);

  logic [LG_W-1:0]   span;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] low_mask;

  always_comb begin
    span     = LG_W'(size_i) + LG_W'(lg_i);
    inc      = addr_i + (ADDR_W'(1) << size_i);
    low_mask = ~({ADDR_W{1'b1}} << span);
    if (wrap_i) next_o = (addr_i & ~low_mask) | (inc & low_mask);
    else        next_o = inc;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3,
  parameter int MAX_LG = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [2:0]        burst,
  input  logic [SIZE_W-1:0] size,
  input  logic              ready,
  input  logic              stall,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        trans,
  output logic              last,
  output logic              done
);

  localparam int BEAT_W = MAX_LG + 1;
  localparam int LGB_W  = $clog2(MAX_LG + 1);
  localparam int LG_W   = $clog2((1 << SIZE_W) + MAX_LG);

  logic [ADDR_W-1:0] addr_q;
  trans_t            trans_q;
  logic              last_q;
  logic              done_q;
  logic [BEAT_W-1:0] remain_q;
  logic [SIZE_W-1:0] size_q;
  logic [LGB_W-1:0]  lg_q;
  logic              wrap_q;
  logic              undef_q;

  logic [LGB_W-1:0]  dec_lg;
  logic              dec_wrap;
  logic              dec_undef;
  logic [ADDR_W-1:0] nxt_addr;
  logic              final_beat;

  bag_decode #(.LGB_W(LGB_W)) u_dec (
    .code_i  (burst),
    .lg_o    (dec_lg),
    .wrap_o  (dec_wrap),
    .undef_o (dec_undef)
  );

  bag_step #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .LGB_W  (LGB_W),
    .LG_W   (LG_W)
  ) u_step (
    .addr_i (addr_q),
    .size_i (size_q),
    .lg_i   (lg_q),
    .wrap_i (wrap_q),
    .next_o (nxt_addr)
  );

  assign final_beat = undef_q ? !start : (remain_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      trans_q  <= TR_IDLE;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
      remain_q <= '0;
      size_q   <= '0;
      lg_q     <= '0;
      wrap_q   <= 1'b0;
      undef_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ready) begin
        case (trans_q)
          TR_IDLE: begin
            if (start) begin
              addr_q   <= start_addr;
              trans_q  <= TR_NSEQ;
              size_q   <= size;
              lg_q     <= dec_lg;
              wrap_q   <= dec_wrap;
              undef_q  <= dec_undef;
              remain_q <= (BEAT_W'(1) << dec_lg) - BEAT_W'(1);
              last_q   <= !dec_undef && (dec_lg == '0);
            end
          end
          TR_BUSY: begin
            if (!stall) begin
              trans_q <= TR_SEQ;
              last_q  <= !undef_q && (remain_q == '0);
            end
          end
          default: begin
            if (final_beat) begin
              trans_q <= TR_IDLE;
              last_q  <= 1'b0;
              done_q  <= 1'b1;
            end else begin
              addr_q <= nxt_addr;
              if (!undef_q) remain_q <= remain_q - BEAT_W'(1);
              if (stall) begin
                trans_q <= TR_BUSY;
                last_q  <= 1'b0;
              end else begin
                trans_q <= TR_SEQ;
                last_q  <= !undef_q && (remain_q == BEAT_W'(1));
              end
            end
          end
        endcase
      end
    end
  end

  assign addr  = addr_q;
  assign trans = trans_q;
  assign last  = last_q;
  assign done  = done_q;

  // high address bits that must not move inside a wrapping burst
  logic [ADDR_W-1:0] wrap_hi;
  assign wrap_hi = {ADDR_W{1'b1}} << (LG_W'(size_q) + LG_W'(lg_q));

  assert_hold_on_wait_R7: assert property (@(posedge clk) disable iff (rst)
    (!ready && trans_q != TR_IDLE) |=> ($stable(addr_q) && $stable(trans_q) && $stable(last_q)));

  assert_single_nonseq_R6: assert property (@(posedge clk) disable iff (rst)
    (ready && trans_q == TR_NSEQ) |=> (trans_q != TR_NSEQ));

  assert_busy_keeps_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (ready && trans_q == TR_BUSY) |=> ($stable(addr_q) && (trans_q == TR_BUSY || trans_q == TR_SEQ)));

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (trans_q == TR_IDLE && !last_q));

  assert_last_on_beat_R9: assert property (@(posedge clk) disable iff (rst)
    last_q |-> (trans_q == TR_NSEQ || trans_q == TR_SEQ));

  assert_wrap_window_R5: assert property (@(posedge clk) disable iff (rst)
    (ready && wrap_q && !last_q && (trans_q == TR_NSEQ || trans_q == TR_SEQ))
      |=> (((addr_q ^ $past(addr_q)) & wrap_hi) == '0));

endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] start_addr;
  logic [2:0]  burst;
  logic [2:0]  size;
  logic        ready;
  logic        stall;
  logic [31:0] addr;
  logic [1:0]  trans;
  logic        last;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  burst_addr_gen u0 (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .burst(burst), .size(size), .ready(ready), .stall(stall),
    .addr(addr), .trans(trans), .last(last), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] a0, input logic [2:0] sz,
                                           input logic [2:0] code, input int i);
    logic [31:0] step;
    logic [31:0] m;
    int lg;
    step = 32'(i) << sz;
    if (code[0] == 1'b0 && code != 3'b000) begin
      lg = int'(code[2:1]) + 1;
      m = (32'd1 << (int'(sz) + lg)) - 32'd1;
      return (a0 & ~m) | ((a0 + step) & m);
    end
    return a0 + step;
  endfunction

  task automatic run_burst(input logic [2:0] code, input logic [2:0] sz,
                           input logic [31:0] a0, input int mode);
    int n;
    int i;
    bit busy;
    bit fin;
    bit r;
    bit s;
    bit wr;
    bit undef;
    undef = (code == 3'b001);
    wr = (code[0] == 1'b0) && (code != 3'b000);
    if (code == 3'b000) n = 1;
    else if (undef) n = 5;
    else n = 1 << (int'(code[2:1]) + 1);
    i = 0; busy = 0; fin = 0;
    @(negedge clk);
    start = 1'b1; start_addr = a0; burst = code; size = sz; ready = 1'b1; stall = 1'b0;
    @(negedge clk);
    chk("R2 first type", 32'(trans), 32'h2);
    chk("R2 first addr", addr, a0);
    chk("R9 last on first", 32'(last), 32'(n == 1 && !undef));
    // live inputs now carry other values; the running burst must ignore them (R2)
    start_addr = ~a0; burst = ~code; size = ~sz;
    while (!fin) begin
      cyc++;
      case (mode)
        0: begin r = 1; s = 0; end
        1: begin r = (cyc % 3) != 1; s = 0; end
        default: begin r = (cyc % 5) != 3; s = (cyc % 4) == 1; end
      endcase
      ready = r; stall = s; start = !(i == n - 1 && !busy);
      @(negedge clk);
      if (r) begin
        if (busy) begin
          if (!s) busy = 0;
        end else if (i == n - 1) fin = 1;
        else begin
          i++;
          busy = s;
        end
      end
      if (fin) begin
        if (undef) chk("R11 end type", 32'(trans), 32'h0);
        else       chk("R3 end type", 32'(trans), 32'h0);
        chk("R10 done pulse", 32'(done), 32'h1);
        chk("R9 last clear", 32'(last), 32'h0);
      end else begin
        if (busy)        chk("R8 type", 32'(trans), 32'h1);
        else if (i == 0) chk("R2 type", 32'(trans), 32'h2);
        else             chk("R6 type", 32'(trans), 32'h3);
        if (!r)      chk("R7 addr hold", addr, exp_addr(a0, sz, code, i));
        else if (wr) chk("R5 wrap addr", addr, exp_addr(a0, sz, code, i));
        else         chk("R4 incr addr", addr, exp_addr(a0, sz, code, i));
        chk("R9 last", 32'(last), 32'(!busy && !undef && i == n - 1));
        chk("R10 no early done", 32'(done), 32'h0);
      end
    end
    start = 1'b0; ready = 1'b1; stall = 1'b0;
    @(negedge clk);
    chk("R10 single cycle", 32'(done), 32'h0);
    chk("R10 idle after", 32'(trans), 32'h0);
  endtask

  initial begin
    logic [31:0] bases [3];
    bases[0] = 32'h0000_1034;
    bases[1] = 32'h8000_07EC;
    bases[2] = 32'hFFFF_FFB4;
    rst = 1'b1; start = 1'b1; start_addr = 32'h1234_5678; burst = 3'b011;
    size = 3'd2; ready = 1'b1; stall = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset type", 32'(trans), 32'h0);
    chk("R1 reset addr", addr, 32'h0);
    chk("R1 reset last", 32'(last), 32'h0);
    chk("R1 reset done", 32'(done), 32'h0);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", 32'(trans), 32'h0);
    // start while ready is low must not be taken
    start = 1'b1; ready = 1'b0;
    @(negedge clk);
    chk("R2 start needs ready", 32'(trans), 32'h0);
    chk("R2 addr unchanged", addr, 32'h0);
    start = 1'b0; ready = 1'b1;
    for (int c = 0; c < 8; c++)
      for (int z = 0; z < 8; z++)
        for (int a = 0; a < 3; a++)
          for (int m = 0; m < 3; m++)
            run_burst(3'(c), 3'(z), bases[a] & ~((32'd1 << z) - 32'd1), m);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule